// File: doc/BRIEF.md
# Shift-Left Execution Unit with Condition Flags

This unit is the logical-left-shift slice of a small CPU datapath that handles 8, 16 and 32-bit operands. Each operation arrives as a two-byte opcode, a 32-bit source register value and an optional 8-bit count register. The unit decodes the operand size and the shift amount. The amount is either an immediate of 1, 2, 4, 8 or 16 taken from the opcode, or the value of the count register.

The shifted value is merged into the untouched upper bytes of the source register. The unit produces a byte write mask for the register file and computes the negative, zero, overflow, carry and half-carry flags. An opcode it does not recognise is flagged as illegal, and both the register write and the flag write are suppressed.

Operations enter through a valid/ready handshake. A single output register presents the outcome one clock after acceptance and holds it while the consumer stalls.

Top module: `shl_flag_unit`

## Requirements
- R1: With first opcode byte 0x10, second bytes 0x08, 0x48 and 0xA8 shift the low byte of the source left by 1, 2 and 4 (0xA5 becomes 0x4A, 0x94 and 0x50).
- R2: Second bytes 0x10, 0x50, 0x20 and 0x60 shift the low 16 bits by 1, 2, 4 and 8 (0xA5A5 becomes 0x4B4A, 0x9694, 0x5A50 and 0xA500).
- R3: Second bytes 0x30, 0x70, 0x38, 0x78 and 0xF8 shift all 32 bits by 1, 2, 4, 8 and 16.
- R4: When `cnt_from_reg` is 1, the size still comes from the second opcode byte but the amount is `cnt_reg` (5 turns 0xA5 into 0xA0, 0xA5A5 into 0xB4A0, and 0xA5A5A5A5 into 0xB4B4B4A0).
- R5: C is the last bit shifted out past the MSB of the sized operand.
- R6: A register count of 0 leaves the operand unchanged and clears C.
- R7: A count equal to the operand width gives zero with C equal to the original bit 0. A count above the width gives zero with C cleared.
- R8: N is the MSB of the sized result and Z is 1 only when the sized result is zero. V and H always read 0.
- R9: `out_wmask` is 0x1, 0x3 or 0xF for byte, word or long operations, and the result bits outside the mask equal the source bits.
- R10: A first byte other than 0x10, or an unlisted second byte, sets `out_illegal`, drives `out_wmask` and `out_flag_we` to 0, passes the source through, and reads all flags as 0.
- R11: `out_valid` is 0 after reset and is 1 in the cycle after an accepted input.
- R12: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the outputs hold. With `out_ready` 1, a new input is accepted in the same cycle as the old output drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| op_hi | input | 8 | First opcode byte |
| op_lo | input | 8 | Second opcode byte (size and immediate count) |
| cnt_from_reg | input | 1 | Take the shift amount from `cnt_reg` |
| cnt_reg | input | 8 | Count register value |
| src_val | input | 32 | Destination register value before the operation |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_valid | output | 1 | Output registers hold a result |
| out_illegal | output | 1 | Opcode was not recognised |
| out_flag_we | output | 1 | Flags are to be written |
| out_wmask | output | 4 | Byte write enables for the destination register |
| out_result | output | 32 | Merged register value |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag (always 0) |
| out_c | output | 1 | Carry flag |
| out_h | output | 1 | Half-carry flag (always 0) |

## Verification
Two events can fall in the same clock: the consumer draining the held result, and the producer handing in the next operation. The bench first holds `out_ready` low for several cycles while an operation waits at the input, then raises it. In that cycle the old result must leave and the waiting operation must be captured, so that the next cycle shows the new result with no bubble. A per-clock reference model with its own valid bit and record judges every cycle, including `in_ready` and the held values.

// File: rtl/shl_pkg.sv
package shl_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2
   } shl_size_e;

   localparam logic [7:0] SHL_PREFIX = 8'h10;

endpackage

// File: rtl/shl_decode.sv
module shl_decode
   import shl_pkg::*;
#(
   parameter int IMM_W = 5
) (
   input  logic [7:0]       op_hi,
   input  logic [7:0]       op_lo,
   output logic             legal,
   output shl_size_e        size,
   output logic [IMM_W-1:0] imm_cnt
);

   logic lo_ok;

   always_comb begin
      lo_ok   = 1'b1;
      size    = SZ_BYTE;
      imm_cnt = '0;
      case (op_lo)
         8'h08: begin size = SZ_BYTE; imm_cnt = IMM_W'(1);  end
         8'h48: begin size = SZ_BYTE; imm_cnt = IMM_W'(2);  end
         8'hA8: begin size = SZ_BYTE; imm_cnt = IMM_W'(4);  end
         8'h10: begin size = SZ_WORD; imm_cnt = IMM_W'(1);  end
         8'h50: begin size = SZ_WORD; imm_cnt = IMM_W'(2);  end
         8'h20: begin size = SZ_WORD; imm_cnt = IMM_W'(4);  end
         8'h60: begin size = SZ_WORD; imm_cnt = IMM_W'(8);  end
         8'h30: begin size = SZ_LONG; imm_cnt = IMM_W'(1);  end
         8'h70: begin size = SZ_LONG; imm_cnt = IMM_W'(2);  end
         8'h38: begin size = SZ_LONG; imm_cnt = IMM_W'(4);  end
         8'h78: begin size = SZ_LONG; imm_cnt = IMM_W'(8);  end
         8'hF8: begin size = SZ_LONG; imm_cnt = IMM_W'(16); end
         default: lo_ok = 1'b0;
      endcase
      legal = lo_ok && (op_hi == SHL_PREFIX);
   end

endmodule

// File: rtl/shl_lane.sv
module shl_lane #(
   parameter int W     = 8,
   parameter int CNT_W = 8
) (
   input  logic [W-1:0]     opnd,
   input  logic [CNT_W-1:0] cnt,
   output logic [W-1:0]     res,
   output logic             carry
);

   localparam int SH_W = $clog2(W) + 1;

   logic [2*W-1:0] wide;

   always_comb begin
      wide = {{W{1'b0}}, opnd} << cnt[SH_W-1:0];
      if (cnt == '0) begin
         res   = opnd;
         carry = 1'b0;
      end else if (cnt > CNT_W'(W)) begin
         res   = '0;
         carry = 1'b0;
      end else begin
         res   = wide[W-1:0];
         carry = wide[W];
      end
   end

endmodule

// File: rtl/shl_flag_unit.sv
module shl_flag_unit
   import shl_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [7:0]        op_hi,
   input  logic [7:0]        op_lo,
   input  logic              cnt_from_reg,
   input  logic [CNT_W-1:0]  cnt_reg,
   input  logic [DATA_W-1:0] src_val,
   input  logic              out_ready,
   output logic              out_valid,
   output logic              out_illegal,
   output logic              out_flag_we,
   output logic [DATA_W/8-1:0] out_wmask,
   output logic [DATA_W-1:0] out_result,
   output logic              out_n,
   output logic              out_z,
   output logic              out_v,
   output logic              out_c,
   output logic              out_h
);

   localparam int NB    = DATA_W / 8;
   localparam int NL    = $clog2(NB) + 1;
   localparam int IMM_W = $clog2(DATA_W / 2) + 1;

   if (NL != 3) begin : g_bad_width
      $error("shl_flag_unit: DATA_W must give exactly byte, word and long lanes");
   end
   if (CNT_W < $clog2(DATA_W) + 1) begin : g_bad_cnt
      $error("shl_flag_unit: CNT_W too narrow for the long lane");
   end

   typedef struct packed {
      logic [DATA_W-1:0] result;
      logic [NB-1:0]     wmask;
      logic              flag_we;
      logic              illegal;
      logic              n;
      logic              z;
      logic              c;
   } shl_out_t;

   logic             legal;
   shl_size_e        size;
   logic [IMM_W-1:0] imm_cnt;
   logic [CNT_W-1:0] cnt_sel;

   shl_decode #(.IMM_W(IMM_W)) u_decode (
      .op_hi   (op_hi),
      .op_lo   (op_lo),
      .legal   (legal),
      .size    (size),
      .imm_cnt (imm_cnt)
   );

   assign cnt_sel = cnt_from_reg ? cnt_reg : CNT_W'(imm_cnt);

   logic [DATA_W-1:0] lane_res  [NL];
   logic [NB-1:0]     lane_mask [NL];
   logic              lane_c    [NL];
   logic              lane_n    [NL];
   logic              lane_z    [NL];

   for (genvar k = 0; k < NL; k++) begin : g_lane
      localparam int LW = 8 << k;
      logic [LW-1:0] r;
      logic          c;
      shl_lane #(.W(LW), .CNT_W(CNT_W)) u_lane (
         .opnd  (src_val[LW-1:0]),
         .cnt   (cnt_sel),
         .res   (r),
         .carry (c)
      );
      assign lane_res[k]  = DATA_W'(r);
      assign lane_mask[k] = NB'({(LW/8){1'b1}});
      assign lane_c[k]    = c;
      assign lane_n[k]    = r[LW-1];
      assign lane_z[k]    = (r == '0);
   end

   int                sel;
   logic [DATA_W-1:0] bit_mask;
   shl_out_t          nxt;
   shl_out_t          pay_q;
   logic              valid_q;
   logic              accept;

   assign sel = int'(size);

   always_comb begin
      for (int b = 0; b < NB; b++) begin
         bit_mask[8*b +: 8] = {8{lane_mask[sel][b]}};
      end
   end

   always_comb begin
      nxt = '0;
      if (legal) begin
         nxt.result  = (src_val & ~bit_mask) | (lane_res[sel] & bit_mask);
         nxt.wmask   = lane_mask[sel];
         nxt.flag_we = 1'b1;
         nxt.n       = lane_n[sel];
         nxt.z       = lane_z[sel];
         nxt.c       = lane_c[sel];
      end else begin
         nxt.result  = src_val;
         nxt.illegal = 1'b1;
      end
   end

   assign in_ready = !valid_q || out_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         pay_q   <= '0;
      end else begin
         if (accept) begin
            pay_q   <= nxt;
            valid_q <= 1'b1;
         end else if (out_ready) begin
            valid_q <= 1'b0;
         end
      end
   end

   assign out_valid   = valid_q;
   assign out_illegal = pay_q.illegal;
   assign out_flag_we = pay_q.flag_we;
   assign out_wmask   = pay_q.wmask;
   assign out_result  = pay_q.result;
   assign out_n       = pay_q.n;
   assign out_z       = pay_q.z;
   assign out_c       = pay_q.c;
   assign out_v       = 1'b0;
   assign out_h       = 1'b0;

endmodule

// File: rtl/shl_flag_unit_chk.sv
module shl_flag_unit_chk #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] src_val,
   input logic              out_ready,
   input logic              out_valid,
   input logic              out_illegal,
   input logic              out_flag_we,
   input logic [DATA_W/8-1:0] out_wmask,
   input logic [DATA_W-1:0] out_result,
   input logic              out_z,
   input logic              out_v,
   input logic              out_h
);

   assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_wmask));

   assert_backpressure_R12: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);

   assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_illegal |-> out_wmask == '0 && !out_flag_we);

   assert_vh_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !out_v && !out_h);

   assert_byte_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_wmask == 4'h1 |-> out_z == (out_result[7:0] == 8'h00));

   assert_upper_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_wmask[1] || out_result[DATA_W-1:8] == $past(src_val[DATA_W-1:8]));

   assert_mask_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_illegal |-> out_wmask != '0 && (out_wmask & (out_wmask + 1'b1)) == '0);

endmodule

bind shl_flag_unit shl_flag_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .src_val     (src_val),
   .out_ready   (out_ready),
   .out_valid   (out_valid),
   .out_illegal (out_illegal),
   .out_flag_we (out_flag_we),
   .out_wmask   (out_wmask),
   .out_result  (out_result),
   .out_z       (out_z),
   .out_v       (out_v),
   .out_h       (out_h)
);

// File: tb/shl_flag_unit_tb_top.sv
`timescale 1ns/1ps
module shl_flag_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  op_hi = 8'h00;
   logic [7:0]  op_lo = 8'h00;
   logic        cnt_from_reg = 1'b0;
   logic [7:0]  cnt_reg = 8'h00;
   logic [31:0] src_val = 32'h0;
   logic        out_ready = 1'b1;
   logic        out_valid, out_illegal, out_flag_we;
   logic [3:0]  out_wmask;
   logic [31:0] out_result;
   logic        out_n, out_z, out_v, out_c, out_h;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   shl_flag_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .op_hi(op_hi), .op_lo(op_lo), .cnt_from_reg(cnt_from_reg), .cnt_reg(cnt_reg),
      .src_val(src_val), .out_ready(out_ready), .out_valid(out_valid),
      .out_illegal(out_illegal), .out_flag_we(out_flag_we), .out_wmask(out_wmask),
      .out_result(out_result), .out_n(out_n), .out_z(out_z), .out_v(out_v),
      .out_c(out_c), .out_h(out_h)
   );

   // reference model state
   bit          m_valid = 0;
   logic [31:0] m_res;
   logic [3:0]  m_wm;
   bit          m_fwe, m_ill, m_n, m_z, m_c;
   string       m_tag = "R11";

   task automatic chk(string tag, string what, bit ok, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic ref_op(input logic [7:0] hi, input logic [7:0] lo, input bit ur,
                         input logic [7:0] rc, input logic [31:0] src);
      int w = 0;
      int cnt = 0;
      longint mask, v;
      bit c = 0;
      case (lo)
         8'h08: begin w = 8;  cnt = 1;  end
         8'h48: begin w = 8;  cnt = 2;  end
         8'hA8: begin w = 8;  cnt = 4;  end
         8'h10: begin w = 16; cnt = 1;  end
         8'h50: begin w = 16; cnt = 2;  end
         8'h20: begin w = 16; cnt = 4;  end
         8'h60: begin w = 16; cnt = 8;  end
         8'h30: begin w = 32; cnt = 1;  end
         8'h70: begin w = 32; cnt = 2;  end
         8'h38: begin w = 32; cnt = 4;  end
         8'h78: begin w = 32; cnt = 8;  end
         8'hF8: begin w = 32; cnt = 16; end
         default: w = 0;
      endcase
      if (hi != 8'h10 || w == 0) begin
         m_res = src; m_wm = 4'h0; m_fwe = 0; m_ill = 1;
         m_n = 0; m_z = 0; m_c = 0;
         return;
      end
      if (ur) cnt = int'(rc);
      mask = (64'd1 << w) - 1;
      v = longint'(src) & mask;
      for (int i = 0; i < cnt; i++) begin
         c = bit'((v >> (w - 1)) & 1);
         v = (v << 1) & mask;
      end
      m_res = 32'((longint'(src) & ~mask) | v);
      m_wm  = (w == 8) ? 4'h1 : (w == 16) ? 4'h3 : 4'hF;
      m_fwe = 1; m_ill = 0;
      m_n = bit'((v >> (w - 1)) & 1);
      m_z = (v == 0);
      m_c = c;
   endtask

   task automatic compare();
      chk("R11", "out_valid", out_valid == m_valid, out_valid, m_valid);
      if (m_valid) begin
         chk(m_tag, "result", out_result == m_res, out_result, m_res);
         chk(m_ill ? "R10" : "R9", "wmask", out_wmask == m_wm, out_wmask, m_wm);
         chk("R10", "illegal", out_illegal == m_ill, out_illegal, m_ill);
         chk("R10", "flag_we", out_flag_we == m_fwe, out_flag_we, m_fwe);
         chk(m_tag, "C", out_c == m_c, out_c, m_c);
         chk("R8", "N", out_n == m_n, out_n, m_n);
         chk("R8", "Z", out_z == m_z, out_z, m_z);
         chk("R8", "V/H", !out_v && !out_h, {out_v, out_h}, 0);
      end
   endtask

   // one clock: compare at negedge, drive, model the coming posedge
   task automatic step(bit iv, logic [7:0] hi, logic [7:0] lo, bit ur,
                       logic [7:0] rc, logic [31:0] src, bit ordy, string tag);
      bit acc;
      compare();
      in_valid = iv; op_hi = hi; op_lo = lo; cnt_from_reg = ur;
      cnt_reg = rc; src_val = src; out_ready = ordy;
      #1;
      chk("R12", "in_ready", in_ready == (!m_valid || ordy), in_ready, !m_valid || ordy);
      acc = iv && (!m_valid || ordy);
      if (acc) begin
         ref_op(hi, lo, ur, rc, src);
         m_valid = 1;
         m_tag = tag;
      end else if (m_valid && !ordy) begin
         m_tag = "R12";
      end else begin
         m_valid = 0;
      end
      @(negedge clk);
   endtask

   task automatic op(logic [7:0] lo, logic [31:0] src, string tag);
      step(1, 8'h10, lo, 0, 8'h00, src, 1, tag);
   endtask

   task automatic rop(logic [7:0] lo, logic [7:0] rc, logic [31:0] src, string tag);
      step(1, 8'h10, lo, 1, rc, src, 1, tag);
   endtask

   task automatic idle();
      step(0, 8'h00, 8'h00, 0, 8'h00, 32'h0, 1, "R11");
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R11 watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11", "reset out_valid", out_valid == 0, out_valid, 0);
      chk("R11", "reset in_ready", in_ready == 1, in_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 byte immediates
      op(8'h08, 32'hA5A5A5A5, "R1");
      op(8'h48, 32'hA5A5A5A5, "R1");
      op(8'hA8, 32'hA5A5A5A5, "R1");
      // R2 word immediates
      op(8'h10, 32'hA5A5A5A5, "R2");
      op(8'h50, 32'hA5A5A5A5, "R2");
      op(8'h20, 32'hA5A5A5A5, "R2");
      op(8'h60, 32'hA5A5A5A5, "R2");
      // R3 long immediates
      op(8'h30, 32'hA5A5A5A5, "R3");
      op(8'h70, 32'hA5A5A5A5, "R3");
      op(8'h38, 32'hA5A5A5A5, "R3");
      op(8'h78, 32'hA5A5A5A5, "R3");
      op(8'hF8, 32'hA5A5A5A5, "R3");
      idle();
      // R4 register count
      rop(8'h08, 8'd5, 32'hA5A5A5A5, "R4");
      rop(8'h10, 8'd5, 32'hA5A5A5A5, "R4");
      rop(8'h30, 8'd5, 32'hA5A5A5A5, "R4");
      // R5 last bit out
      op(8'h48, 32'h000000C0, "R5");
      op(8'h60, 32'h000001FF, "R5");
      // R6 zero count
      rop(8'h30, 8'd0, 32'h80000001, "R6");
      rop(8'h08, 8'd0, 32'h000000FF, "R6");
      // R7 count at and above width
      rop(8'h08, 8'd8, 32'hA5A5A5A5, "R7");
      rop(8'h10, 8'd33, 32'hFFFFFFFF, "R7");
      rop(8'h30, 8'd200, 32'hFFFFFFFF, "R7");
      rop(8'h30, 8'd32, 32'h00000001, "R7");
      // R8 flags
      op(8'h08, 32'hFFFFFF80, "R8");
      op(8'h10, 32'h00004000, "R8");
      // R9 partial writes
      op(8'h08, 32'h12345678, "R9");
      op(8'h50, 32'h12345678, "R9");
      // R10 illegal encodings
      step(1, 8'h11, 8'h08, 0, 8'h00, 32'hDEADBEEF, 1, "R10");
      step(1, 8'h10, 8'h00, 0, 8'h00, 32'hCAFEF00D, 1, "R10");
      step(1, 8'h10, 8'hFF, 1, 8'd3, 32'h01020304, 1, "R10");
      idle();
      // R12 stall with a waiting operation, then drain and accept together
      op(8'h30, 32'h0F0F0F0F, "R12");
      step(1, 8'h10, 8'h70, 0, 8'h00, 32'h11111111, 0, "R12");
      step(1, 8'h10, 8'h70, 0, 8'h00, 32'h11111111, 0, "R12");
      step(1, 8'h10, 8'h70, 0, 8'h00, 32'h11111111, 0, "R12");
      step(1, 8'h10, 8'h70, 0, 8'h00, 32'h11111111, 1, "R12");
      step(0, 8'h00, 8'h00, 0, 8'h00, 32'h0, 0, "R12");
      step(0, 8'h00, 8'h00, 0, 8'h00, 32'h0, 1, "R12");
      idle();
      idle();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule